// File: doc/BRIEF.md
# USB Host Pipe Reset and Enable Controller

This block holds the per-pipe enable, reset and data-toggle control for a USB host that has `NPIPE` pipes. Firmware writes through a small register port. A pipe becomes active only when firmware enables it. Firmware can then put the pipe into reset at any moment by setting that pipe's reset bit. While the bit is set, the controller drives the pipe's datapath reset, which clears the transfer state machine and the bank FIFO counters. The pipe's sticky status bit is also held at zero. The pipe stays enabled during reset, and its configuration word and data-toggle value are left as they were. The reset ends only when firmware clears the bit.

A separate one-shot request sets the data-toggle sequence back to DATA0. Disabling a pipe holds it in reset and also clears its toggle. A broadcast de-allocate input from the port controller clears every enable bit, and the allocation bit of every configuration word, on one clock edge.

Each pipe is controlled by a three-state machine:
- `PS_OFF`: disabled. The pipe is held in reset and its toggle is forced to DATA0.
- `PS_HOLD`: enabled, with its reset bit set.
- `PS_RUN`: enabled and operating.

The transitions are:
- `PS_OFF` to `PS_HOLD` on enable while the reset bit is set.
- `PS_OFF` to `PS_RUN` on enable while the reset bit is clear.
- `PS_RUN` to `PS_HOLD` when the reset bit is set.
- `PS_HOLD` to `PS_RUN` when the reset bit is cleared.
- `PS_RUN` or `PS_HOLD` to `PS_OFF` when the enable bit is cleared or a de-allocate occurs.

The state moves on the same edge as the register write that causes the move.

Top module: `upr_top`

## Requirements
- R1: After reset, `pipe_en` is all zeros and `pipe_rst` is all ones. Every toggle is 00, every status bit is 0 and every configuration word is 0.
- R2: A write to address 0 loads the enable bits, with bit i for pipe i. An enabled pipe whose reset bit is clear shows `pipe_en`=1 and `pipe_rst`=0 right after the write edge.
- R3: A write to address 1 loads the reset bits, with bit i for pipe i. An enabled pipe with its bit set shows `pipe_rst`=1 while `pipe_en` stays 1. Writing the bit back to 0 releases the reset after the write edge.
- R4: In `PS_RUN`, a pulse on `ev_set[i]` sets the sticky `pipe_stat[i]`. Entering `PS_HOLD` or `PS_OFF` clears it, and `ev_set` is ignored until the pipe returns to `PS_RUN`.
- R5: Entering or staying in `PS_HOLD` leaves the pipe's configuration word and toggle value unchanged.
- R6: A write to address 2 with bit i set requests a toggle clear for pipe i. The request lasts one cycle, and the toggle reads 00 from the second edge after the write. Afterwards the toggle advances normally again.
- R7: In `PS_RUN`, a `tgl_adv[i]` pulse moves the toggle from 00 (DATA0) to 01 (DATA1), and from 01 back to 00. In `PS_HOLD` and `PS_OFF` the pulse is ignored.
- R8: Disabling a pipe forces its toggle to 00 and its `pipe_rst` to 1. The toggle is still 00 after the pipe is enabled again.
- R9: `dealloc_all` clears every enable bit and bit 0 (the allocation bit) of every configuration word on the same edge. The other configuration bits are kept. If an enable write arrives in the same cycle, the de-allocate wins.
- R10: When a pending toggle clear and a `tgl_adv` pulse fall in the same cycle for one pipe, the toggle becomes 00.
- R11: A write to address 4+i loads pipe i's configuration word. The write is accepted in every state, including `PS_HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| dealloc_all | input | 1 | Broadcast de-allocate from the port controller |
| tgl_adv | input | NPIPE | Per-pipe toggle advance from the datapath |
| ev_set | input | NPIPE | Per-pipe status event from the datapath |
| pipe_en | output | NPIPE | Per-pipe enable to the datapath |
| pipe_rst | output | NPIPE | Per-pipe hold-in-reset to the datapath |
| pipe_stat | output | NPIPE | Per-pipe sticky status bit |
| pipe_tgl | output | 2*NPIPE | Toggle sequence; pipe i occupies bits [2i+1:2i] |
| pipe_cfg | output | CW*NPIPE | Configuration words; pipe i occupies bits [CW*i +: CW] |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both on purpose.

The first pair is a one-shot toggle clear and a toggle advance on the same pipe. The bench writes the clear request and then, one cycle later, pulses `tgl_adv`, so that the advance coincides with the pending request. It starts from DATA0, because an advance alone would then give 01 while the correct result is 00.

The second pair is a de-allocate and an enable write. The bench asserts `dealloc_all` in the cycle of a write that enables every pipe. It then expects all enables to be zero and the allocation bits to be cleared, with the other configuration bits kept.

// File: rtl/upr_pkg.sv
package upr_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_HOLD = 2'd1,
        PS_RUN  = 2'd2
    } pipe_state_e;

    localparam logic [1:0] TGL_DATA0 = 2'b00;
    localparam logic [1:0] TGL_DATA1 = 2'b01;

    localparam int ADR_ENA  = 0;
    localparam int ADR_RST  = 1;
    localparam int ADR_TGL  = 2;
    localparam int ADR_CFG0 = 4;

    localparam int ALLOC_BIT = 0;

endpackage

// File: rtl/upr_regfile.sv
module upr_regfile
    import upr_pkg::*;
#(
    parameter int NPIPE = 4,
    parameter int CW    = 12,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CW-1:0]       wr_data,
    input  logic                dealloc_all,
    output logic [NPIPE-1:0]    en_nxt,
    output logic [NPIPE-1:0]    rst_nxt,
    output logic [NPIPE-1:0]    tgl_clr,
    output logic [CW*NPIPE-1:0] cfg_q
);

    logic [NPIPE-1:0] en_q;
    logic [NPIPE-1:0] rst_q;
    logic [NPIPE-1:0] tgl_req_d;
    logic             sel_ena;
    logic             sel_rst;
    logic             sel_tgl;

    assign sel_ena = wr_en && (wr_addr == AW'(ADR_ENA));
    assign sel_rst = wr_en && (wr_addr == AW'(ADR_RST));
    assign sel_tgl = wr_en && (wr_addr == AW'(ADR_TGL));

    always_comb begin
        en_nxt = en_q;
        if (sel_ena) begin
            en_nxt = wr_data[NPIPE-1:0];
        end
        if (dealloc_all) begin
            en_nxt = '0;
        end
    end

    always_comb begin
        rst_nxt = rst_q;
        if (sel_rst) begin
            rst_nxt = wr_data[NPIPE-1:0];
        end
    end

    assign tgl_req_d = sel_tgl ? wr_data[NPIPE-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            rst_q   <= '0;
            tgl_clr <= '0;
        end else begin
            en_q    <= en_nxt;
            rst_q   <= rst_nxt;
            tgl_clr <= tgl_req_d;
        end
    end

    for (genvar i = 0; i < NPIPE; i++) begin : g_cfg
        logic [CW-1:0] cfg_r;
        logic [CW-1:0] cfg_d;

        always_comb begin
            cfg_d = cfg_r;
            if (wr_en && (wr_addr == AW'(ADR_CFG0 + i))) begin
                cfg_d = wr_data;
            end
            if (dealloc_all) begin
                cfg_d[ALLOC_BIT] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r <= '0;
            end else begin
                cfg_r <= cfg_d;
            end
        end

        assign cfg_q[CW*i +: CW] = cfg_r;
    end

endmodule

// File: rtl/upr_pipe_fsm.sv
module upr_pipe_fsm
    import upr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_nxt,
    input  logic       rst_nxt,
    input  logic       tgl_clr,
    input  logic       tgl_adv,
    input  logic       ev_set,
    output logic       pipe_en,
    output logic       pipe_rst,
    output logic       pipe_stat,
    output logic [1:0] pipe_tgl
);

    pipe_state_e state_q;
    pipe_state_e state_d;
    logic [1:0]  tgl_q;
    logic        stat_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF: begin
                if (en_nxt) begin
                    state_d = rst_nxt ? PS_HOLD : PS_RUN;
                end
            end
            PS_HOLD: begin
                if (!en_nxt) begin
                    state_d = PS_OFF;
                end else if (!rst_nxt) begin
                    state_d = PS_RUN;
                end
            end
            PS_RUN: begin
                if (!en_nxt) begin
                    state_d = PS_OFF;
                end else if (rst_nxt) begin
                    state_d = PS_HOLD;
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pipe_en  = 1'b0;
        pipe_rst = 1'b1;
        unique case (state_q)
            PS_OFF: begin
                pipe_en  = 1'b0;
                pipe_rst = 1'b1;
            end
            PS_HOLD: begin
                pipe_en  = 1'b1;
                pipe_rst = 1'b1;
            end
            PS_RUN: begin
                pipe_en  = 1'b1;
                pipe_rst = 1'b0;
            end
            default: begin
                pipe_en  = 1'b0;
                pipe_rst = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= TGL_DATA0;
        end else if (state_d == PS_OFF) begin
            tgl_q <= TGL_DATA0;
        end else if (tgl_clr) begin
            tgl_q <= TGL_DATA0;
        end else if (tgl_adv && state_q == PS_RUN && state_d == PS_RUN) begin
            tgl_q <= (tgl_q == TGL_DATA0) ? TGL_DATA1 : TGL_DATA0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (state_d != PS_RUN) begin
            stat_q <= 1'b0;
        end else begin
            stat_q <= stat_q | ev_set;
        end
    end

    assign pipe_stat = stat_q;
    assign pipe_tgl  = tgl_q;

endmodule

// File: rtl/upr_top.sv
module upr_top
    import upr_pkg::*;
#(
    parameter int NPIPE = 4,
    parameter int CW    = 12,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CW-1:0]       wr_data,
    input  logic                dealloc_all,
    input  logic [NPIPE-1:0]    tgl_adv,
    input  logic [NPIPE-1:0]    ev_set,
    output logic [NPIPE-1:0]    pipe_en,
    output logic [NPIPE-1:0]    pipe_rst,
    output logic [NPIPE-1:0]    pipe_stat,
    output logic [2*NPIPE-1:0]  pipe_tgl,
    output logic [CW*NPIPE-1:0] pipe_cfg
);

    localparam int TW = 2;

    logic [NPIPE-1:0] en_nxt;
    logic [NPIPE-1:0] rst_nxt;
    logic [NPIPE-1:0] tgl_clr;

    upr_regfile #(
        .NPIPE (NPIPE),
        .CW    (CW),
        .AW    (AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .dealloc_all (dealloc_all),
        .en_nxt      (en_nxt),
        .rst_nxt     (rst_nxt),
        .tgl_clr     (tgl_clr),
        .cfg_q       (pipe_cfg)
    );

    for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
        upr_pipe_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_nxt    (en_nxt[i]),
            .rst_nxt   (rst_nxt[i]),
            .tgl_clr   (tgl_clr[i]),
            .tgl_adv   (tgl_adv[i]),
            .ev_set    (ev_set[i]),
            .pipe_en   (pipe_en[i]),
            .pipe_rst  (pipe_rst[i]),
            .pipe_stat (pipe_stat[i]),
            .pipe_tgl  (pipe_tgl[TW*i +: TW])
        );
    end

endmodule

// File: rtl/upr_checker.sv
module upr_checker #(
    parameter int NPIPE = 4,
    parameter int CW    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                dealloc_all,
    input logic [NPIPE-1:0]    pipe_en,
    input logic [NPIPE-1:0]    pipe_rst,
    input logic [NPIPE-1:0]    pipe_stat,
    input logic [2*NPIPE-1:0]  pipe_tgl,
    input logic [CW*NPIPE-1:0] pipe_cfg
);

    p_cfg_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !dealloc_all) |=> $stable(pipe_cfg));

    p_dealloc_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_all |=> (pipe_en == '0));

    for (genvar i = 0; i < NPIPE; i++) begin : g_chk
        p_off_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !pipe_en[i] |-> (pipe_rst[i] && pipe_tgl[2*i +: 2] == 2'b00));

        p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_rst[i] |-> !pipe_stat[i]);

        p_hold_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_en[i] && pipe_rst[i] && !wr_en && !$past(wr_en) && !dealloc_all)
            |=> $stable(pipe_tgl[2*i +: 2]));

        p_dealloc_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
            dealloc_all |=> !pipe_cfg[CW*i]);
    end

endmodule

bind upr_top upr_checker #(
    .NPIPE (NPIPE),
    .CW    (CW)
) u_upr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .dealloc_all (dealloc_all),
    .pipe_en     (pipe_en),
    .pipe_rst    (pipe_rst),
    .pipe_stat   (pipe_stat),
    .pipe_tgl    (pipe_tgl),
    .pipe_cfg    (pipe_cfg)
);

// File: tb/tb_upr_top.sv
module tb_upr_top;

    localparam int NPIPE = 4;
    localparam int CW    = 12;
    localparam int AW    = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [AW-1:0]       wr_addr = '0;
    logic [CW-1:0]       wr_data = '0;
    logic                dealloc_all = 1'b0;
    logic [NPIPE-1:0]    tgl_adv = '0;
    logic [NPIPE-1:0]    ev_set = '0;
    logic [NPIPE-1:0]    pipe_en;
    logic [NPIPE-1:0]    pipe_rst;
    logic [NPIPE-1:0]    pipe_stat;
    logic [2*NPIPE-1:0]  pipe_tgl;
    logic [CW*NPIPE-1:0] pipe_cfg;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] exp_cfg [NPIPE];

    always #5 clk = ~clk;

    upr_top #(.NPIPE(NPIPE), .CW(CW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dealloc_all(dealloc_all), .tgl_adv(tgl_adv),
        .ev_set(ev_set), .pipe_en(pipe_en), .pipe_rst(pipe_rst),
        .pipe_stat(pipe_stat), .pipe_tgl(pipe_tgl), .pipe_cfg(pipe_cfg)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic adv(input logic [NPIPE-1:0] m);
        @(negedge clk);
        tgl_adv = m;
        @(negedge clk);
        tgl_adv = '0;
    endtask

    task automatic ev(input logic [NPIPE-1:0] m);
        @(negedge clk);
        ev_set = m;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic t_reset_state;
        chk("R1 en", 64'(pipe_en), 64'h0);
        chk("R1 rst", 64'(pipe_rst), 64'hF);
        chk("R1 tgl", 64'(pipe_tgl), 64'h0);
        chk("R1 stat", 64'(pipe_stat), 64'h0);
        chk("R1 cfg", 64'(pipe_cfg), 64'h0);
    endtask

    task automatic t_enable;
        for (int i = 0; i < NPIPE; i++) begin
            exp_cfg[i] = CW'(12'h351 + i * 12'h110);
            wr(4 + i, exp_cfg[i]);
        end
        for (int i = 0; i < NPIPE; i++) begin
            chk("R11 cfg write", 64'(pipe_cfg[CW*i +: CW]), 64'(exp_cfg[i]));
        end
        wr(0, CW'(4'b0101));
        chk("R2 en", 64'(pipe_en), 64'h5);
        chk("R2 rst", 64'(pipe_rst), 64'hA);
    endtask

    task automatic t_run;
        adv(4'b0011);
        chk("R7 adv run", 64'(pipe_tgl[1:0]), 64'h1);
        chk("R7 adv off ignored", 64'(pipe_tgl[3:2]), 64'h0);
        ev(4'b0011);
        chk("R4 sticky", 64'(pipe_stat), 64'h1);
    endtask

    task automatic t_pipe_reset;
        wr(1, CW'(4'b0001));
        chk("R3 rst set", 64'(pipe_rst), 64'hB);
        chk("R3 en kept", 64'(pipe_en), 64'h5);
        chk("R4 stat cleared", 64'(pipe_stat), 64'h0);
        chk("R5 tgl kept", 64'(pipe_tgl[1:0]), 64'h1);
        chk("R5 cfg kept", 64'(pipe_cfg[CW-1:0]), 64'(exp_cfg[0]));
        adv(4'b0001);
        chk("R7 adv in hold ignored", 64'(pipe_tgl[1:0]), 64'h1);
        ev(4'b0001);
        chk("R4 ev in hold ignored", 64'(pipe_stat), 64'h0);
        exp_cfg[0] = 12'h7A5;
        wr(4, exp_cfg[0]);
        chk("R11 cfg in hold", 64'(pipe_cfg[CW-1:0]), 64'(exp_cfg[0]));
        wr(1, '0);
        chk("R3 release", 64'(pipe_rst), 64'hA);
        chk("R5 tgl after release", 64'(pipe_tgl[1:0]), 64'h1);
    endtask

    task automatic t_tgl_clear;
        wr(2, CW'(4'b0001));
        chk("R6 first edge", 64'(pipe_tgl[1:0]), 64'h1);
        @(negedge clk);
        chk("R6 cleared", 64'(pipe_tgl[1:0]), 64'h0);
        adv(4'b0001);
        chk("R6 one-shot", 64'(pipe_tgl[1:0]), 64'h1);
        adv(4'b0001);
        chk("R7 back to data0", 64'(pipe_tgl[1:0]), 64'h0);
    endtask

    task automatic t_clash;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = CW'(4'b0001);
        @(negedge clk);
        wr_en = 1'b0; tgl_adv = 4'b0001;
        @(negedge clk);
        tgl_adv = '0;
        chk("R10 clear wins", 64'(pipe_tgl[1:0]), 64'h0);
    endtask

    task automatic t_disable;
        adv(4'b0001);
        chk("R7 adv", 64'(pipe_tgl[1:0]), 64'h1);
        wr(0, CW'(4'b0100));
        chk("R8 en", 64'(pipe_en), 64'h4);
        chk("R8 rst", 64'(pipe_rst), 64'hB);
        chk("R8 tgl", 64'(pipe_tgl[1:0]), 64'h0);
        wr(0, CW'(4'b0101));
        chk("R8 tgl after re-enable", 64'(pipe_tgl[1:0]), 64'h0);
    endtask

    task automatic t_dealloc;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(0); wr_data = CW'(4'b1111); dealloc_all = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; dealloc_all = 1'b0;
        chk("R9 en cleared", 64'(pipe_en), 64'h0);
        for (int i = 0; i < NPIPE; i++) begin
            chk("R9 alloc cleared", 64'(pipe_cfg[CW*i +: CW]), 64'(exp_cfg[i] & ~CW'(1)));
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_enable;
        t_run;
        t_pipe_reset;
        t_tgl_clear;
        t_clash;
        t_disable;
        t_dealloc;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule